// File: doc/BRIEF.md
# Packed Integer Vector ALU

This block is a single-cycle execution unit for packed integer vector arithmetic. Each operation takes two 128-bit operands and treats them as a row of independent lanes. The lanes are 8, 16, 32 or 64 bits wide, so there are 16, 8, 4 or 2 of them. A 2-bit size code selects the lane width and a 5-bit operation code selects the function. The unit registers its result, so the answer appears one clock after the request.

The functions are:
- modular addition and subtraction;
- clamped addition and subtraction, signed and unsigned;
- lane compares that return masks of all ones or all zeros;
- signed and unsigned minimum and maximum;
- four logic operations that ignore the lane width;
- a gather of the top bit of every byte into a 16-bit scalar.

Any combination the unit does not support raises an error flag and returns zero. A decode stage upstream can use this flag to trap.

Top module: `pvec_alu`

## Requirements
- R1: Size code 0/1/2/3 selects 8/16/32/64-bit lanes. Opcode 0 adds and opcode 1 subtracts (a minus b) each lane modulo 2^width, for every size. A carry or borrow never crosses into the next lane.
- R2: The unsigned clamped operations are opcode 3 (add) and opcode 5 (subtract, a minus b). A result above the lane's maximum becomes all ones. A result below zero becomes 0.
- R3: The signed clamped operations are opcode 2 (add) and opcode 4 (subtract). A result that leaves the two's-complement range becomes the most positive or the most negative lane value.
- R4: Opcodes 2 to 5 with size code 2 or 3 raise `err_o` and give an all-zero result.
- R5: Opcode 6 (equal) and opcode 7 (signed a greater than b) write all ones into a lane when the test holds and zeros when it fails. This applies to size codes 0 to 2. With size code 3 these opcodes raise `err_o` and give zero.
- R6: Opcodes 8/9 give the signed/unsigned minimum and opcodes 10/11 give the signed/unsigned maximum of each lane, for every size.
- R7: Opcodes 12 to 15 compute a AND b, (NOT a) AND b, a OR b and a XOR b over the whole vector. The size code has no effect on them.
- R8: Opcode 16 returns, in result bit i, the top bit of byte i of `a_i`. Bit 0 comes from byte 0. All higher result bits are zero. `b_i` and the size code have no effect.
- R9: When `in_vld_i` is high, `out_vld_o`, `res_o` and `err_o` update on the next rising edge. When `in_vld_i` is low, `out_vld_o` falls and `res_o` and `err_o` hold their values.
- R10: Synchronous active-high reset clears `out_vld_o`, `res_o` and `err_o`.
- R11: Opcodes 17 to 31 raise `err_o` and give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld_i | input | 1 | Request strobe |
| op_i | input | 5 | Operation code |
| size_i | input | 2 | Lane width code |
| a_i | input | 128 | First operand |
| b_i | input | 128 | Second operand |
| out_vld_o | output | 1 | Result strobe, one cycle after the request |
| res_o | output | 128 | Registered result |
| err_o | output | 1 | Unsupported opcode/size combination |

## Verification
The in-line properties assume that `op_i`, `size_i` and the operands are sampled only in cycles where `in_vld_i` is high. They also assume that reset is held during the first clock edge, so that no `$past` value comes from before reset. The bench meets both conditions: it drives every input at the falling edge, raises the strobe for exactly one cycle per request, and keeps reset high for several cycles at the start. The sweep covers all 32 opcodes at all four size codes. It uses operand patterns placed at the signed and unsigned clamp limits of each lane width, plus equal and random pairs. This ensures every legal and every flagged combination is reached.

// File: rtl/pvec_pkg.sv
package pvec_pkg;

    localparam int VEC_W   = 128;
    localparam int OP_W    = 5;
    localparam int SZ_W    = 2;
    localparam int N_SIZES = 4;
    localparam int BASE_W  = 8;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_SUB   = 5'd1,
        OP_SADDS = 5'd2,
        OP_UADDS = 5'd3,
        OP_SSUBS = 5'd4,
        OP_USUBS = 5'd5,
        OP_CEQ   = 5'd6,
        OP_CGT   = 5'd7,
        OP_SMIN  = 5'd8,
        OP_UMIN  = 5'd9,
        OP_SMAX  = 5'd10,
        OP_UMAX  = 5'd11,
        OP_AND   = 5'd12,
        OP_ANDN  = 5'd13,
        OP_OR    = 5'd14,
        OP_XOR   = 5'd15,
        OP_MSB   = 5'd16
    } op_e;

    typedef struct packed {
        logic use_lane;
        logic use_bit;
        logic use_msb;
        logic bad;
    } dec_t;

    function automatic dec_t decode(input op_e op, input logic [SZ_W-1:0] sz);
        dec_t d;
        d = '0;
        if (op > OP_MSB) begin
            d.bad = 1'b1;
        end else if (op == OP_MSB) begin
            d.use_msb = 1'b1;
        end else if (op >= OP_AND) begin
            d.use_bit = 1'b1;
        end else begin
            d.use_lane = 1'b1;
            if (op >= OP_SADDS && op <= OP_USUBS && sz >= 2'd2) d.bad = 1'b1;
            if ((op == OP_CEQ || op == OP_CGT) && sz == 2'd3) d.bad = 1'b1;
        end
        return d;
    endfunction

endpackage

// File: rtl/pvec_lane.sv
module pvec_lane
    import pvec_pkg::*;
#(
    parameter int W = 8
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0] sum_x, dif_x;
    logic       ov_add, ov_sub, s_gt, u_gt;

    always_comb begin
        sum_x  = {1'b0, a} + {1'b0, b};
        dif_x  = {1'b0, a} - {1'b0, b};
        ov_add = (a[W-1] == b[W-1]) && (sum_x[W-1] != a[W-1]);
        ov_sub = (a[W-1] != b[W-1]) && (dif_x[W-1] != a[W-1]);
        s_gt   = $signed(a) > $signed(b);
        u_gt   = a > b;
        unique case (op)
            OP_ADD:   y = sum_x[W-1:0];
            OP_SUB:   y = dif_x[W-1:0];
            OP_SADDS: y = ov_add ? (a[W-1] ? S_MIN : S_MAX) : sum_x[W-1:0];
            OP_UADDS: y = sum_x[W] ? '1 : sum_x[W-1:0];
            OP_SSUBS: y = ov_sub ? (a[W-1] ? S_MIN : S_MAX) : dif_x[W-1:0];
            OP_USUBS: y = dif_x[W] ? '0 : dif_x[W-1:0];
            OP_CEQ:   y = (a == b) ? '1 : '0;
            OP_CGT:   y = s_gt ? '1 : '0;
            OP_SMIN:  y = s_gt ? b : a;
            OP_UMIN:  y = u_gt ? b : a;
            OP_SMAX:  y = s_gt ? a : b;
            OP_UMAX:  y = u_gt ? a : b;
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/pvec_lane_row.sv
module pvec_lane_row
    import pvec_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int LANE_W = 8
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    localparam int N_LANES = DATA_W / LANE_W;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        pvec_lane #(.W(LANE_W)) lane_i (
            .op (op),
            .a  (a[i*LANE_W +: LANE_W]),
            .b  (b[i*LANE_W +: LANE_W]),
            .y  (y[i*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/pvec_logic.sv
module pvec_logic
    import pvec_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        unique case (op)
            OP_AND:  y = a & b;
            OP_ANDN: y = ~a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/pvec_alu.sv
module pvec_alu
    import pvec_pkg::*;
#(
    parameter int DATA_W = VEC_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_vld_i,
    input  logic [OP_W-1:0]     op_i,
    input  logic [SZ_W-1:0]     size_i,
    input  logic [DATA_W-1:0]   a_i,
    input  logic [DATA_W-1:0]   b_i,
    output logic                out_vld_o,
    output logic [DATA_W-1:0]   res_o,
    output logic                err_o
);
    localparam int N_BYTES = DATA_W / BASE_W;

    op_e               op;
    dec_t              dec;
    logic [DATA_W-1:0] row_y [N_SIZES];
    logic [DATA_W-1:0] logic_y;
    logic [N_BYTES-1:0] msb_y;
    logic [DATA_W-1:0] nxt;

    assign op  = op_e'(op_i);
    assign dec = decode(op, size_i);

    for (genvar s = 0; s < N_SIZES; s++) begin : g_row
        pvec_lane_row #(.DATA_W(DATA_W), .LANE_W(BASE_W << s)) row_i (
            .op (op),
            .a  (a_i),
            .b  (b_i),
            .y  (row_y[s])
        );
    end

    pvec_logic #(.DATA_W(DATA_W)) logic_i (
        .op (op),
        .a  (a_i),
        .b  (b_i),
        .y  (logic_y)
    );

    for (genvar k = 0; k < N_BYTES; k++) begin : g_msb
        assign msb_y[k] = a_i[k*BASE_W + BASE_W - 1];
    end

    always_comb begin
        nxt = '0;
        if (dec.bad)          nxt = '0;
        else if (dec.use_msb) nxt = {{(DATA_W-N_BYTES){1'b0}}, msb_y};
        else if (dec.use_bit) nxt = logic_y;
        else if (dec.use_lane) nxt = row_y[size_i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld_o <= 1'b0;
            res_o     <= '0;
            err_o     <= 1'b0;
        end else begin
            out_vld_o <= in_vld_i;
            if (in_vld_i) begin
                res_o <= nxt;
                err_o <= dec.bad;
            end
        end
    end

    function automatic logic bytes_uniform(input logic [DATA_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < N_BYTES; i++)
            if (v[i*BASE_W +: BASE_W] != '0 && v[i*BASE_W +: BASE_W] != '1) ok = 1'b0;
        return ok;
    endfunction

    p_reset_clear_r10: assert property (@(posedge clk) rst |=> !out_vld_o && !err_o && res_o == '0);
    p_vld_follow_r9: assert property (@(posedge clk) disable iff (rst) in_vld_i |=> out_vld_o);
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !in_vld_i |=> !out_vld_o && $stable(res_o) && $stable(err_o));
    p_wide_sat_flag_r4: assert property (@(posedge clk) disable iff (rst)
        in_vld_i && op_i >= 5'd2 && op_i <= 5'd5 && size_i[1] |=> err_o);
    p_err_zero_r11: assert property (@(posedge clk) disable iff (rst) err_o |-> res_o == '0);
    p_msb_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
        in_vld_i && op_i == 5'd16 |=> res_o[DATA_W-1:N_BYTES] == '0 && !err_o);
    p_cmp_mask_r5: assert property (@(posedge clk) disable iff (rst)
        in_vld_i && (op_i == 5'd6 || op_i == 5'd7) && size_i == 2'd0 |=> bytes_uniform(res_o));
    p_xor_r7: assert property (@(posedge clk) disable iff (rst)
        in_vld_i && op_i == 5'd15 |=> res_o == $past(a_i ^ b_i));
endmodule

// File: tb/pvec_alu_tb_top.sv
module pvec_alu_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_vld_i = 1'b0;
    logic [4:0]   op_i = '0;
    logic [1:0]   size_i = '0;
    logic [127:0] a_i = '0, b_i = '0;
    logic         out_vld_o, err_o;
    logic [127:0] res_o;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    pvec_alu dut_i (
        .clk(clk), .rst(rst), .in_vld_i(in_vld_i), .op_i(op_i), .size_i(size_i),
        .a_i(a_i), .b_i(b_i), .out_vld_o(out_vld_o), .res_o(res_o), .err_o(err_o)
    );

    function automatic string req_of(input int op);
        if (op <= 1) return "R1";
        if (op == 3 || op == 5) return "R2";
        if (op == 2 || op == 4) return "R3";
        if (op <= 7) return "R5";
        if (op <= 11) return "R6";
        if (op <= 15) return "R7";
        if (op == 16) return "R8";
        return "R11";
    endfunction

    function automatic void model(input int op, input int sz, input logic [127:0] a, b,
                                  output logic [127:0] r, output logic ill);
        int w, n;
        logic [63:0] msk, ua, ub;
        logic signed [65:0] sa, sb, za, zb, v, smax, smin, umax, one;
        r = '0; ill = 1'b0;
        w = 8 << sz; n = 128 / w;
        one = 66'sd1;
        if (op > 16) begin ill = 1'b1; return; end
        if (op == 16) begin
            for (int i = 0; i < 16; i++) r[i] = a[8*i+7];
            return;
        end
        if (op >= 2 && op <= 5 && sz > 1) begin ill = 1'b1; return; end
        if ((op == 6 || op == 7) && sz == 3) begin ill = 1'b1; return; end
        case (op)
            12: begin r = a & b; return; end
            13: begin r = ~a & b; return; end
            14: begin r = a | b; return; end
            15: begin r = a ^ b; return; end
            default: ;
        endcase
        msk  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        smax = (one <<< (w-1)) - one;
        smin = -(one <<< (w-1));
        umax = (one <<< w) - one;
        for (int i = 0; i < n; i++) begin
            ua = 64'(a >> (i*w)) & msk;
            ub = 64'(b >> (i*w)) & msk;
            za = $signed({2'b0, ua});
            zb = $signed({2'b0, ub});
            sa = ua[w-1] ? za - (one <<< w) : za;
            sb = ub[w-1] ? zb - (one <<< w) : zb;
            case (op)
                0: v = za + zb;
                1: v = za - zb;
                2: begin v = sa + sb; if (v > smax) v = smax; if (v < smin) v = smin; end
                3: begin v = za + zb; if (v > umax) v = umax; end
                4: begin v = sa - sb; if (v > smax) v = smax; if (v < smin) v = smin; end
                5: begin v = za - zb; if (v < 0) v = 0; end
                6: v = (ua == ub) ? -one : 0;
                7: v = (sa > sb) ? -one : 0;
                8: v = (sa < sb) ? sa : sb;
                9: v = (za < zb) ? za : zb;
                10: v = (sa > sb) ? sa : sb;
                default: v = (za > zb) ? za : zb;
            endcase
            r = r | (128'(v[63:0] & msk) << (i*w));
        end
    endfunction

    task automatic check(input string req, input logic [127:0] got, exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic run_one(input int op, input int sz, input logic [127:0] a, b);
        logic [127:0] er; logic ei;
        model(op, sz, a, b, er, ei);
        @(negedge clk);
        in_vld_i = 1'b1; op_i = 5'(op); size_i = 2'(sz); a_i = a; b_i = b;
        @(negedge clk);
        in_vld_i = 1'b0;
        check(req_of(op), res_o, er, $sformatf("res op=%0d sz=%0d", op, sz));
        check(ei ? "R4" : req_of(op), {127'd0, err_o}, {127'd0, ei}, $sformatf("err op=%0d sz=%0d", op, sz));
        check("R9", {127'd0, out_vld_o}, 128'd1, "out_vld after request");
    endtask

    logic [127:0] pa [14];
    logic [127:0] pb [14];

    initial begin
        pa[0] = {16{8'h7f}};        pb[0] = {16{8'h01}};
        pa[1] = {16{8'h80}};        pb[1] = {16{8'hff}};
        pa[2] = '1;                 pb[2] = '1;
        pa[3] = '0;                 pb[3] = {16{8'h01}};
        pa[4] = {8{16'h7fff}};      pb[4] = {8{16'h0001}};
        pa[5] = {8{16'h8000}};      pb[5] = {8{16'h0001}};
        pa[6] = {4{32'h80000000}};  pb[6] = {4{32'h00000001}};
        pa[7] = '1;                 pb[7] = {2{64'h1}};
        pa[8] = {8{16'h00ff}};      pb[8] = {8{16'h0001}};
        pa[9] = {16{8'h5a}};        pb[9] = {16{8'h5a}};
        for (int i = 10; i < 14; i++) begin
            pa[i] = {$urandom, $urandom, $urandom, $urandom};
            pb[i] = {$urandom, $urandom, $urandom, $urandom};
        end
        pb[13][63:0] = pa[13][63:0];

        repeat (4) @(negedge clk);
        // R10: reset state
        check("R10", res_o, '0, "res after reset");
        check("R10", {126'd0, out_vld_o, err_o}, '0, "flags after reset");
        rst = 1'b0;

        for (int op = 0; op < 32; op++)
            for (int sz = 0; sz < 4; sz++)
                for (int p = 0; p < 14; p++)
                    run_one(op, sz, pa[p], pb[p]);

        // R9: idle cycle holds result while inputs change
        run_one(0, 0, pa[0], pb[0]);
        @(negedge clk);
        op_i = 5'd15; a_i = '1; b_i = '0;
        begin
            logic [127:0] held; held = res_o;
            @(negedge clk);
            check("R9", res_o, held, "hold when idle");
            check("R9", {127'd0, out_vld_o}, 128'd0, "out_vld low when idle");
        end
        // R8: b and size have no effect on byte-top gather
        run_one(16, 3, {16{8'h80}}, '1);
        check("R8", res_o, 128'h0000_ffff, "gather all tops");
        // R7: logic ops identical at every size
        for (int sz = 0; sz < 4; sz++) begin
            run_one(13, sz, pa[10], pb[10]);
            check("R7", res_o, ~pa[10] & pb[10], "andnot size independence");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule